// File: doc/BRIEF.md
# External Interrupt Sense Controller

This peripheral conditions eight external interrupt request pins and one non-maskable interrupt pin before they reach a parent interrupt controller. Each pin is first brought into the clock domain by a two-flop synchroniser. A small per-pin state machine decides when the synchronised value can be trusted as a reference, so leaving reset never looks like an edge. Each of the eight lines has its own 2-bit trigger mode: low level, falling edge, rising edge or both edges. A qualifying event latches a pending flag, and that flag drives the line's output to the parent controller directly.

Software reaches three 16-bit registers through a simple write strobe and a combinational read port, addressed by byte offset. The mode register packs the eight 2-bit trigger fields. The pending register holds one flag per line. A flag is cleared by writing 0 to its bit; writing 1 leaves it untouched, so one line is cleared by writing all ones except that bit. The NMI register reads back the synchronised NMI level, selects the NMI edge polarity and holds the NMI flag, which uses the same write-0-to-clear rule. Prioritisation, masking and vectoring belong to the parent controller.

Each pin conditioner steps through the states `SY_FILL0` → `SY_FILL1` → `SY_ARM` → `SY_LIVE`, advancing one state per clock. `SY_FILL0` loads the first synchroniser flop. `SY_FILL1` loads the second. In `SY_ARM` the previous-value reference is taken from the now-valid synchronised level. `SY_LIVE` is terminal: events are detected only there, and the only way out is reset.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, irq_o and nmi_o are 0, every field of the mode register (offset 2) is 0 (low level), the pending register (offset 4) reads 0, and the NMI register (offset 0) shows a falling-edge selection (bit 8 = 0) with its flag (bit 1) clear.
- R2: The mode register at byte offset 2 is fully writable and readable. Line n uses bits [2n+1:2n], encoded 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges.
- R3: In low-level mode (0) the pending flag of a line is set on every clock while its synchronised pin is low. A clear takes effect only after the pin has gone high.
- R4: In falling-edge mode (1) a high-to-low transition of the pin sets the line's pending flag, and a low-to-high transition does not.
- R5: In rising-edge mode (2) a low-to-high transition sets the pending flag, and a high-to-low transition does not.
- R6: In both-edges mode (3) either transition sets the pending flag.
- R7: Writing the pending register (offset 4) clears flag n when bit n of the written data is 0. A 1 leaves that flag unchanged.
- R8: When a detected event and a clear of the same flag occur in the same clock, the flag stays set.
- R9: In the NMI register (offset 0), bit 15 reads the synchronised NMI pin level and ignores writes. Bit 8 selects the NMI edge (0 = falling, 1 = rising). Bit 1 is the NMI flag: it is set by the selected edge and cleared by writing 0 to bit 1. nmi_o equals that flag.
- R10: irq_o[n] equals pending flag n, and the pending register reads it at bit n with bits 15:8 zero.
- R11: A pin level that is present at reset and held after it is never taken as an edge.
- R12: Writes to any offset other than 0, 2 or 4 change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 8 | Asynchronous external interrupt request pins |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| irq_o | output | 8 | Per-line requests to the parent controller |
| nmi_o | output | 1 | NMI request to the parent controller |

## Verification
The assertions assume that the write strobe is synchronous and lasts exactly one clock. They also assume that a pin change the block is meant to see stays stable for at least three clocks, long enough to cross both synchroniser flops and the reference flop. The stimulus changes pins and registers only on falling clock edges, holds every pin level for four or more clocks, and issues each register write as a single-cycle strobe. The sweep covers every line in every mode. The same-cycle clear-versus-event case is timed by counting the two synchroniser registers, so the clear lands exactly in the cycle the edge is detected.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'd0,
        SNS_FALL = 2'd1,
        SNS_RISE = 2'd2,
        SNS_BOTH = 2'd3
    } sense_e;

    typedef enum logic [1:0] {
        SY_FILL0 = 2'd0,
        SY_FILL1 = 2'd1,
        SY_ARM   = 2'd2,
        SY_LIVE  = 2'd3
    } sync_state_e;

    localparam int REG_W       = 16;
    localparam int ADDR_W      = 3;
    localparam logic [ADDR_W-1:0] OFF_NMI   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_SENSE = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_PEND  = 3'd4;
    localparam int NMI_LVL_BIT  = 15;
    localparam int NMI_EDGE_BIT = 8;
    localparam int NMI_FLAG_BIT = 1;

endpackage

// File: rtl/pin_conditioner.sv
module pin_conditioner
    import ext_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic lvl_o,
    output logic prev_o,
    output logic live_o
);

    logic        meta_q;
    logic        sync_q;
    logic        prev_q;
    sync_state_e state_q;
    sync_state_e state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SY_FILL0: state_d = SY_FILL1;
            SY_FILL1: state_d = SY_ARM;
            SY_ARM:   state_d = SY_LIVE;
            SY_LIVE:  state_d = SY_LIVE;
            default:  state_d = SY_FILL0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SY_FILL0;
        else         state_q <= state_d;
    end

    assign lvl_o  = sync_q;
    assign prev_o = prev_q;
    assign live_o = (state_q == SY_LIVE);

    a_r11_live_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_o |=> live_o);

endmodule

// File: rtl/irq_line_latch.sv
module irq_line_latch
    import ext_irq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  sense_e mode_i,
    input  logic   lvl_i,
    input  logic   prev_i,
    input  logic   live_i,
    input  logic   clr_i,
    output logic   pend_o
);

    logic evt;
    logic pend_q;

    always_comb begin
        evt = 1'b0;
        if (live_i) begin
            unique case (mode_i)
                SNS_LOW:  evt = !lvl_i;
                SNS_FALL: evt = prev_i && !lvl_i;
                SNS_RISE: evt = !prev_i && lvl_i;
                SNS_BOTH: evt = prev_i ^ lvl_i;
                default:  evt = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    pend_q <= 1'b0;
        else if (evt)   pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt |=> pend_o);
    a_r7_hold_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !clr_i) |=> pend_o);
    a_r7_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !evt) |=> !pend_o);

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_LINES-1:0] irq_pin_i,
    input  logic              nmi_pin_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic [N_LINES-1:0] irq_o,
    output logic              nmi_o
);

    localparam int SENSE_W = 2 * N_LINES;

    logic [SENSE_W-1:0] sense_q;
    logic               nmi_rise_q;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] line_clr;
    logic               wr_sense;
    logic               wr_pend;
    logic               wr_nmi;
    logic               nmi_lvl;
    logic               nmi_prev;
    logic               nmi_live;
    logic               nmi_flag;
    sense_e             nmi_mode;

    assign wr_sense = reg_wr_i && (reg_addr_i == OFF_SENSE);
    assign wr_pend  = reg_wr_i && (reg_addr_i == OFF_PEND);
    assign wr_nmi   = reg_wr_i && (reg_addr_i == OFF_NMI);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sense_q    <= '0;
            nmi_rise_q <= 1'b0;
        end else begin
            if (wr_sense) sense_q    <= reg_wdata_i[SENSE_W-1:0];
            if (wr_nmi)   nmi_rise_q <= reg_wdata_i[NMI_EDGE_BIT];
        end
    end

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        logic lvl, prev, live;

        pin_conditioner u_cond (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (irq_pin_i[n]),
            .lvl_o  (lvl),
            .prev_o (prev),
            .live_o (live)
        );

        assign line_clr[n] = wr_pend && !reg_wdata_i[n];

        irq_line_latch u_latch (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .mode_i (sense_e'(sense_q[2*n +: 2])),
            .lvl_i  (lvl),
            .prev_i (prev),
            .live_i (live),
            .clr_i  (line_clr[n]),
            .pend_o (pend[n])
        );
    end

    pin_conditioner u_nmi_cond (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (nmi_pin_i),
        .lvl_o  (nmi_lvl),
        .prev_o (nmi_prev),
        .live_o (nmi_live)
    );

    assign nmi_mode = nmi_rise_q ? SNS_RISE : SNS_FALL;

    irq_line_latch u_nmi_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .mode_i (nmi_mode),
        .lvl_i  (nmi_lvl),
        .prev_i (nmi_prev),
        .live_i (nmi_live),
        .clr_i  (wr_nmi && !reg_wdata_i[NMI_FLAG_BIT]),
        .pend_o (nmi_flag)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            OFF_NMI: begin
                reg_rdata_o[NMI_LVL_BIT]  = nmi_lvl;
                reg_rdata_o[NMI_EDGE_BIT] = nmi_rise_q;
                reg_rdata_o[NMI_FLAG_BIT] = nmi_flag;
            end
            OFF_SENSE: reg_rdata_o[SENSE_W-1:0] = sense_q;
            OFF_PEND:  reg_rdata_o[N_LINES-1:0] = pend;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o = pend;
    assign nmi_o = nmi_flag;

    a_r2_sense_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_sense |=> (sense_q == $past(reg_wdata_i[SENSE_W-1:0])));
    a_r12_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !wr_sense && !wr_nmi) |=> (sense_q == $past(sense_q)));

endmodule

// File: tb/ext_irq_sense_tb_top.sv
module ext_irq_sense_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic        nmi_pin = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [7:0]  irq_out;
    logic        nmi_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ext_irq_sense dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_pin_i   (irq_pin),
        .nmi_pin_i   (nmi_pin),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq_out),
        .nmi_o       (nmi_out)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    initial begin
        logic [15:0] rv;
        logic [7:0]  bitn;
        logic [7:0]  exp;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(6);

        // R1 / R11: reset state, held pin levels give no event
        check("R1 irq_o", {8'h0, irq_out}, 16'h0);
        check("R11 nmi_o", {15'h0, nmi_out}, 16'h0);
        rd_reg(3'd2, rv); check("R1 sense reg", rv, 16'h0000);
        rd_reg(3'd4, rv); check("R1 pend reg", rv, 16'h0000);
        rd_reg(3'd0, rv); check("R1 nmi reg", rv, 16'h0000);

        // R2: mode register read-back
        wr_reg(3'd2, 16'hA5C3);
        rd_reg(3'd2, rv); check("R2 sense readback", rv, 16'hA5C3);
        wr_reg(3'd2, 16'h0000);

        // R3..R7, R10: sweep every line in every mode
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 4; m++) begin
                bitn = 8'(1 << n);
                wr_reg(3'd2, 16'(m << (2 * n)));
                wr_reg(3'd4, 16'h0000);
                irq_pin[n] = 1'b0;
                wait_cyc(4);
                exp = (m != 2) ? bitn : 8'h0;
                check($sformatf("R4/R5/R6 fall line%0d mode%0d", n, m), {8'h0, irq_out}, {8'h0, exp});
                rd_reg(3'd4, rv);
                check($sformatf("R10 pend read line%0d mode%0d", n, m), rv, {8'h0, exp});
                wr_reg(3'd4, {8'hFF, ~bitn});
                exp = (m == 0) ? bitn : 8'h0;
                check($sformatf("R3/R7 clear while low line%0d mode%0d", n, m), {8'h0, irq_out}, {8'h0, exp});
                irq_pin[n] = 1'b1;
                wait_cyc(4);
                exp = (m != 1) ? bitn : 8'h0;
                check($sformatf("R3/R4/R5/R6 rise line%0d mode%0d", n, m), {8'h0, irq_out}, {8'h0, exp});
                wr_reg(3'd4, 16'hFFFF);
                check($sformatf("R7 write ones keeps line%0d mode%0d", n, m), {8'h0, irq_out}, {8'h0, exp});
                wr_reg(3'd4, 16'h0000);
                check($sformatf("R3/R7 clear high line%0d mode%0d", n, m), {8'h0, irq_out}, 16'h0);
            end
        end

        // R8: clear and new edge in the same cycle, line 3 both edges
        wr_reg(3'd2, 16'(3 << 6));
        irq_pin[3] = 1'b0;
        wait_cyc(4);
        check("R8 pre set", {8'h0, irq_out}, 16'h0008);
        irq_pin[3] = 1'b1;         // next posedges: meta, sync (event live)
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = 3'd4; wdata = 16'hFFF7; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        check("R8 event beats clear", {8'h0, irq_out}, 16'h0008);
        wr_reg(3'd4, 16'hFFF7);
        check("R8 later clear", {8'h0, irq_out}, 16'h0000);

        // R12: stray offsets
        irq_pin[3] = 1'b0;
        wait_cyc(4);
        wr_reg(3'd6, 16'h0000);
        wr_reg(3'd1, 16'h0000);
        check("R12 stray write no clear", {8'h0, irq_out}, 16'h0008);
        rd_reg(3'd2, rv); check("R12 sense unchanged", rv, 16'h00C0);
        rd_reg(3'd6, rv); check("R12 stray read", rv, 16'h0000);
        wr_reg(3'd2, 16'h0000);
        irq_pin[3] = 1'b1;
        wait_cyc(4);
        wr_reg(3'd4, 16'h0000);

        // R9: NMI register
        nmi_pin = 1'b1;
        wait_cyc(4);
        check("R9 rise ignored in fall mode", {15'h0, nmi_out}, 16'h0);
        rd_reg(3'd0, rv); check("R9 level bit", rv, 16'h8000);
        nmi_pin = 1'b0;
        wait_cyc(4);
        check("R9 fall sets nmi_o", {15'h0, nmi_out}, 16'h1);
        rd_reg(3'd0, rv); check("R9 flag read", rv, 16'h0002);
        wr_reg(3'd0, 16'hFFFF);
        rd_reg(3'd0, rv); check("R9 write ones keeps flag", rv, 16'h0102);
        wr_reg(3'd0, 16'h0100);
        rd_reg(3'd0, rv); check("R9 clear flag", rv, 16'h0100);
        nmi_pin = 1'b1;
        wait_cyc(4);
        check("R9 rise sets nmi_o", {15'h0, nmi_out}, 16'h1);
        wr_reg(3'd0, 16'h8100);
        rd_reg(3'd0, rv); check("R9 clear keeps level", rv, 16'h8100);
        check("R9 nmi_o cleared", {15'h0, nmi_out}, 16'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL all: watchdog expired, got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule